// File: doc/BRIEF.md
# Decimal-capable 8-bit accumulator ALU

This block is the arithmetic and logic core of a small 8-bit accumulator processor. Within one cycle, and with no internal state, it computes add-with-carry, subtract-with-borrow, register compare and bit-test. The inputs are the accumulator, a memory operand, a compare register (the accumulator or an index register, chosen by the caller) and the current status flags. It returns the new result byte and the new status flags, each with a write enable, so the register file around it only needs to latch what is enabled.

When the decimal input is high, add and subtract apply digit-wise BCD correction to the result byte. The flags then follow the processor's historical quirks. For add, zero comes from the plain binary sum, and negative and overflow come from a partially corrected intermediate value. For subtract, every flag comes from the binary computation. The carry flag doubles as the carry-in and borrow input. Flags that an operation leaves alone pass through from the status input unchanged.

Top module: `acc_alu`

## Requirements
- R1: Operation select encoding is 0 = add, 1 = subtract, 2 = compare, 3 = bit-test. Status bit positions are 0 = C, 1 = Z, 2 = V, 3 = N, and the carry-in is status bit 0. In binary mode, add returns the low 8 bits of A+M+C in the result, and C is set when that sum exceeds 255.
- R2: For add, Z is set exactly when the low 8 bits of the binary sum A+M+C are zero, whether or not decimal mode is active.
- R3: For binary add, N is result bit 7, and V is set when A and M share bit 7 and the result's bit 7 differs from A's.
- R4: For decimal add with valid BCD operands, the result is the two-digit BCD value of (A+M+C) mod 100, and C is set when that decimal sum reaches 100.
- R5: For decimal add, N and V come from the intermediate value formed after the low-digit adjustment and before the +0x60 high-digit adjustment. The intermediate is (A&0xF0)+(M&0xF0)+(low carry<<4)+(adjusted low digit), and V uses the same sign rule as R3.
- R6: Subtract computes the binary sum A+(~M&0xFF)+C. In both modes C, Z, N and V come from that sum, with V computed against the inverted operand. In binary mode the result is its low 8 bits.
- R7: For decimal subtract with valid BCD operands, the result is the BCD value of A−M−(1−C), with 100 added when that value is negative.
- R8: Compare sets C when the compare register is unsigned greater than or equal to the operand, and takes Z and N from the 8-bit difference. It holds V, leaves result_out equal to the accumulator and holds result_we low.
- R9: Bit-test copies operand bit 7 into N and bit 6 into V, sets Z when A AND M is zero, holds C, leaves result_out equal to the accumulator and holds result_we low.
- R10: status_we is 4'b1111 for add and subtract, 4'b1011 for compare and 4'b1110 for bit-test. Each status_out bit whose enable is low equals the matching status_in bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 2 | Operation: 0 add, 1 subtract, 2 compare, 3 bit-test |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Memory operand |
| cmp_reg_in | input | 8 | Register compared against the operand (accumulator or index) |
| status_in | input | 4 | Current flags {N,V,Z,C}; bit 0 is also the carry-in |
| decimal_in | input | 1 | Decimal mode enable |
| result_out | output | 8 | Result byte (the accumulator for compare and bit-test) |
| result_we | output | 1 | Result write enable |
| status_out | output | 4 | New flags {N,V,Z,C} |
| status_we | output | 4 | Per-flag update mask |

## Verification
Binary add and subtract are swept over every operand pair with both carry-in values. This separates the carry, overflow and zero logic from one another, because every sign combination and every wrap occurs. Decimal add and subtract are swept over every valid BCD pair with both carry-in values. In that sweep the result digits expose the nibble corrections. Zero, taken from the binary sum, and negative and overflow, taken from the intermediate value, only match when each flag is read from its proper point. Directed compare and bit-test patterns cover equal, above, below and sign-crossing values. Each of these runs with status_in ones and zeros, so a held flag that leaks a computed value is caught.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_CMP = 2'd2,
      OP_BIT = 2'd3
   } alu_op_e;

   // bit 3..0 = N, V, Z, C
   typedef struct packed {
      logic n;
      logic v;
      logic z;
      logic c;
   } flags_t;

   localparam logic [3:0] WE_ALL = 4'b1111;
   localparam logic [3:0] WE_CMP = 4'b1011;
   localparam logic [3:0] WE_BIT = 4'b1110;

endpackage

// File: rtl/acc_alu_add.sv
module acc_alu_add
   import acc_alu_pkg::*;
#(
   parameter int W      = 8,
   parameter bit DEC_EN = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] m_i,
   input  logic         c_i,
   input  logic         dec_i,
   output logic [W-1:0] sum_o,
   output flags_t       fl_o
);

   logic [W:0] bin;
   logic       bin_v;

   always_comb begin
      bin   = {1'b0, a_i} + {1'b0, m_i} + {{W{1'b0}}, c_i};
      bin_v = ~(a_i[W-1] ^ m_i[W-1]) & (a_i[W-1] ^ bin[W-1]);
      // R1
      add_carry_order_chk: assert (bin[W] ? (bin[W-1:0] <= a_i) : (bin[W-1:0] >= a_i))
         else $error("add carry inconsistent with result ordering");
   end

   generate
      if (DEC_EN) begin : g_bcd
         logic [5:0] lo;
         logic       lo_cy;
         logic [9:0] mid;
         logic [9:0] fin;
         logic       ops_bcd;

         always_comb begin
            lo = {2'b0, a_i[3:0]} + {2'b0, m_i[3:0]} + {5'b0, c_i};
            if (lo > 6'd9) lo = lo + 6'd6;
            lo_cy = (lo > 6'd15);
            mid = {2'b0, a_i[7:4], 4'b0} + {2'b0, m_i[7:4], 4'b0}
                + {5'b0, lo_cy, 4'b0} + {6'b0, lo[3:0]};
            fin = (mid > 10'h09F) ? (mid + 10'h060) : mid;
            ops_bcd = (a_i[3:0] <= 4'd9) && (a_i[7:4] <= 4'd9)
                   && (m_i[3:0] <= 4'd9) && (m_i[7:4] <= 4'd9);
            // R4
            bcd_sum_digit_chk: assert (!ops_bcd || ((fin[3:0] <= 4'd9) && (fin[7:4] <= 4'd9)))
               else $error("decimal sum digit out of range");
         end

         always_comb begin
            fl_o.z = (bin[W-1:0] == '0);
            if (dec_i) begin
               sum_o  = fin[7:0];
               fl_o.c = (fin > 10'h0FF);
               fl_o.n = mid[7];
               fl_o.v = ~(a_i[7] ^ m_i[7]) & (a_i[7] ^ mid[7]);
            end else begin
               sum_o  = bin[W-1:0];
               fl_o.c = bin[W];
               fl_o.n = bin[W-1];
               fl_o.v = bin_v;
            end
         end
      end else begin : g_bin
         logic unused_dec;
         always_comb begin
            unused_dec = dec_i;
            sum_o  = bin[W-1:0];
            fl_o.z = (bin[W-1:0] == '0);
            fl_o.c = bin[W];
            fl_o.n = bin[W-1];
            fl_o.v = bin_v;
         end
      end
   endgenerate

endmodule

// File: rtl/acc_alu_sub.sv
module acc_alu_sub
   import acc_alu_pkg::*;
#(
   parameter int W      = 8,
   parameter bit DEC_EN = 1'b1
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] m_i,
   input  logic         c_i,
   input  logic         dec_i,
   output logic [W-1:0] diff_o,
   output flags_t       fl_o
);

   logic [W-1:0] m_inv;
   logic [W:0]   bin;

   always_comb begin
      m_inv = ~m_i;
      bin   = {1'b0, a_i} + {1'b0, m_inv} + {{W{1'b0}}, c_i};
      fl_o.c = bin[W];
      fl_o.z = (bin[W-1:0] == '0);
      fl_o.n = bin[W-1];
      fl_o.v = ~(a_i[W-1] ^ m_inv[W-1]) & (a_i[W-1] ^ bin[W-1]);
      // R6
      sub_borrow_order_chk: assert (!bin[W] || (bin[W-1:0] <= a_i))
         else $error("subtract without borrow exceeded minuend");
   end

   generate
      if (DEC_EN) begin : g_bcd
         logic [9:0] lo;
         logic [9:0] hi;
         logic       ops_bcd;

         always_comb begin
            lo = {6'b0, a_i[3:0]} - {6'b0, m_i[3:0]} - {9'b0, ~c_i};
            if (lo[9]) lo = ((lo - 10'd6) & 10'h00F) - 10'h010;
            hi = {2'b0, a_i[7:4], 4'b0} - {2'b0, m_i[7:4], 4'b0} + lo;
            if (hi[9]) hi = hi - 10'h060;
            ops_bcd = (a_i[3:0] <= 4'd9) && (a_i[7:4] <= 4'd9)
                   && (m_i[3:0] <= 4'd9) && (m_i[7:4] <= 4'd9);
            // R7
            bcd_diff_digit_chk: assert (!ops_bcd || ((hi[3:0] <= 4'd9) && (hi[7:4] <= 4'd9)))
               else $error("decimal difference digit out of range");
         end

         always_comb diff_o = dec_i ? hi[7:0] : bin[W-1:0];
      end else begin : g_bin
         logic unused_dec;
         always_comb begin
            unused_dec = dec_i;
            diff_o = bin[W-1:0];
         end
      end
   endgenerate

endmodule

// File: rtl/acc_alu_cmp.sv
module acc_alu_cmp
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] r_i,
   input  logic [W-1:0] m_i,
   output flags_t       fl_o
);

   logic [W:0] d;

   always_comb begin
      d = {1'b0, r_i} - {1'b0, m_i};
      fl_o.c = ~d[W];
      fl_o.z = (d[W-1:0] == '0);
      fl_o.n = d[W-1];
      fl_o.v = 1'b0;
      // R8
      cmp_equal_implies_ge_chk: assert (!fl_o.z || fl_o.c)
         else $error("compare equal without carry");
   end

endmodule

// File: rtl/acc_alu_bit.sv
module acc_alu_bit
   import acc_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] m_i,
   output flags_t       fl_o
);

   always_comb begin
      fl_o.n = m_i[W-1];
      fl_o.v = m_i[W-2];
      fl_o.z = ((a_i & m_i) == '0);
      fl_o.c = 1'b0;
      // R9
      bit_zero_top_chk: assert (!fl_o.z || !(a_i[W-1] && fl_o.n))
         else $error("bit-test zero with shared top bit");
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int W      = 8,
   parameter bit DEC_EN = 1'b1
) (
   input  logic [1:0]   op_sel,
   input  logic [W-1:0] acc_in,
   input  logic [W-1:0] opnd_in,
   input  logic [W-1:0] cmp_reg_in,
   input  logic [3:0]   status_in,
   input  logic         decimal_in,
   output logic [W-1:0] result_out,
   output logic         result_we,
   output logic [3:0]   status_out,
   output logic [3:0]   status_we
);

   localparam int NFLAG = 4;

   generate
      if (W < 4 || (W % 4) != 0) begin : g_bad_width
         $error("acc_alu: W must be a multiple of 4 and at least 4");
      end
      if (DEC_EN && W != 8) begin : g_bad_dec
         $error("acc_alu: decimal mode requires W == 8");
      end
   endgenerate

   logic [W-1:0] add_res, sub_res;
   flags_t       add_fl, sub_fl, cmp_fl, bit_fl;
   flags_t       cur_fl;
   alu_op_e      op;

   acc_alu_add #(.W(W), .DEC_EN(DEC_EN)) u_add (
      .a_i(acc_in), .m_i(opnd_in), .c_i(status_in[0]), .dec_i(decimal_in),
      .sum_o(add_res), .fl_o(add_fl));

   acc_alu_sub #(.W(W), .DEC_EN(DEC_EN)) u_sub (
      .a_i(acc_in), .m_i(opnd_in), .c_i(status_in[0]), .dec_i(decimal_in),
      .diff_o(sub_res), .fl_o(sub_fl));

   acc_alu_cmp #(.W(W)) u_cmp (
      .r_i(cmp_reg_in), .m_i(opnd_in), .fl_o(cmp_fl));

   acc_alu_bit #(.W(W)) u_bit (
      .a_i(acc_in), .m_i(opnd_in), .fl_o(bit_fl));

   always_comb begin
      op = alu_op_e'(op_sel);
      unique case (op)
         OP_ADD:  begin cur_fl = add_fl; status_we = WE_ALL; result_we = 1'b1; result_out = add_res; end
         OP_SUB:  begin cur_fl = sub_fl; status_we = WE_ALL; result_we = 1'b1; result_out = sub_res; end
         OP_CMP:  begin cur_fl = cmp_fl; status_we = WE_CMP; result_we = 1'b0; result_out = acc_in;  end
         default: begin cur_fl = bit_fl; status_we = WE_BIT; result_we = 1'b0; result_out = acc_in;  end
      endcase
      for (int i = 0; i < NFLAG; i++)
         status_out[i] = status_we[i] ? cur_fl[i] : status_in[i];
      // R10
      mask_coverage_chk: assert ($countones(status_we) >= 3 && (!result_we || status_we == WE_ALL))
         else $error("update mask malformed");
   end

endmodule

// File: tb/sim_acc_alu.sv
`timescale 1ns/1ps
module sim_acc_alu;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] op_sel = 2'd0;
   logic [7:0] acc_in = 8'd0, opnd_in = 8'd0, cmp_reg_in = 8'd0;
   logic [3:0] status_in = 4'd0;
   logic       decimal_in = 1'b0;
   logic [7:0] result_out;
   logic       result_we;
   logic [3:0] status_out, status_we;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   acc_alu u0 (
      .op_sel(op_sel), .acc_in(acc_in), .opnd_in(opnd_in), .cmp_reg_in(cmp_reg_in),
      .status_in(status_in), .decimal_in(decimal_in),
      .result_out(result_out), .result_we(result_we),
      .status_out(status_out), .status_we(status_we));

   task automatic chk(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] op, input logic [7:0] a, input logic [7:0] m,
                        input logic [7:0] r, input logic [3:0] st, input logic dec);
      op_sel = op; acc_in = a; opnd_in = m; cmp_reg_in = r; status_in = st; decimal_in = dec;
      #2;
   endtask

   function automatic int to_dec(input int b); return (b >> 4) * 10 + (b & 15); endfunction
   function automatic int to_bcd(input int d); return ((d / 10) << 4) | (d % 10); endfunction

   task automatic t_power_on;
      drive(2'd0, 8'h00, 8'h00, 8'h00, 4'h0, 1'b0);
      chk("R1 idle result", result_out, 0);
      chk("R2 idle zero flag", status_out, 4'b0010);
      chk("R10 idle enables", {result_we, status_we}, 5'b11111);
   endtask

   task automatic t_bin_add_all;
      for (int a = 0; a < 256; a++)
         for (int m = 0; m < 256; m++)
            for (int c = 0; c < 2; c++) begin
               int s, r, v;
               s = a + m + c; r = s & 255;
               v = (((a ^ m) & 8'h80) == 0 && ((a ^ r) & 8'h80) != 0) ? 1 : 0;
               drive(2'd0, 8'(a), 8'(m), 8'h00, {3'b000, c[0]}, 1'b0);
               chk("R1 add result/carry", {status_out[0], result_out}, ((s > 255 ? 1 : 0) << 8) | r);
               chk("R2 add zero", status_out[1], r == 0 ? 1 : 0);
               chk("R3 add N/V", {status_out[3], status_out[2]}, ((r >> 7) << 1) | v);
            end
   endtask

   task automatic t_bin_sub_all;
      for (int a = 0; a < 256; a++)
         for (int m = 0; m < 256; m++)
            for (int c = 0; c < 2; c++) begin
               int mi, s, r, v, exp_st;
               mi = (~m) & 255; s = a + mi + c; r = s & 255;
               v = (((a ^ mi) & 8'h80) == 0 && ((a ^ r) & 8'h80) != 0) ? 1 : 0;
               exp_st = ((r >> 7) << 3) | (v << 2) | ((r == 0 ? 1 : 0) << 1) | (s > 255 ? 1 : 0);
               drive(2'd1, 8'(a), 8'(m), 8'h00, {3'b000, c[0]}, 1'b0);
               chk("R6 sub result", result_out, r);
               chk("R6 sub flags", status_out, exp_st);
               chk("R10 sub enables", {result_we, status_we}, 5'b11111);
            end
   endtask

   task automatic t_dec_add_all;
      for (int da = 0; da < 100; da++)
         for (int dm = 0; dm < 100; dm++)
            for (int c = 0; c < 2; c++) begin
               int a, m, s, lo, hc, mid, v, bs;
               a = to_bcd(da); m = to_bcd(dm); s = da + dm + c;
               lo = (a & 15) + (m & 15) + c;
               if (lo > 9) lo = lo + 6;
               hc = (lo > 15) ? 1 : 0;
               mid = (a & 8'hF0) + (m & 8'hF0) + (hc << 4) + (lo & 15);
               v = (((a ^ m) & 8'h80) == 0 && ((a ^ mid) & 8'h80) != 0) ? 1 : 0;
               bs = (a + m + c) & 255;
               drive(2'd0, 8'(a), 8'(m), 8'h00, {3'b000, c[0]}, 1'b1);
               chk("R4 decimal add result", result_out, to_bcd(s % 100));
               chk("R4 decimal add carry", status_out[0], s >= 100 ? 1 : 0);
               chk("R2 decimal add zero", status_out[1], bs == 0 ? 1 : 0);
               chk("R5 decimal add N/V", {status_out[3], status_out[2]}, (((mid >> 7) & 1) << 1) | v);
            end
   endtask

   task automatic t_dec_sub_all;
      for (int da = 0; da < 100; da++)
         for (int dm = 0; dm < 100; dm++)
            for (int c = 0; c < 2; c++) begin
               int a, m, d, mi, s, r, v, exp_st;
               a = to_bcd(da); m = to_bcd(dm);
               d = da - dm - (1 - c);
               if (d < 0) d = d + 100;
               mi = (~m) & 255; s = a + mi + c; r = s & 255;
               v = (((a ^ mi) & 8'h80) == 0 && ((a ^ r) & 8'h80) != 0) ? 1 : 0;
               exp_st = ((r >> 7) << 3) | (v << 2) | ((r == 0 ? 1 : 0) << 1) | (s > 255 ? 1 : 0);
               drive(2'd1, 8'(a), 8'(m), 8'h00, {3'b000, c[0]}, 1'b1);
               chk("R7 decimal sub result", result_out, to_bcd(d));
               chk("R6 decimal sub binary flags", status_out, exp_st);
            end
   endtask

   task automatic t_compare;
      int pats [6][2] = '{'{8'h40, 8'h40}, '{8'h41, 8'h40}, '{8'h40, 8'h41},
                          '{8'h00, 8'hFF}, '{8'hFF, 8'h00}, '{8'h80, 8'h01}};
      for (int p = 0; p < 6; p++)
         for (int h = 0; h < 2; h++) begin
            int r, m, d, st_in, exp_st;
            r = pats[p][0]; m = pats[p][1]; d = (r - m) & 255;
            st_in = h ? 4'hF : 4'h0;
            exp_st = ((d >> 7) << 3) | (st_in & 4'b0100) | ((d == 0 ? 1 : 0) << 1) | (r >= m ? 1 : 0);
            drive(2'd2, 8'h5A, 8'(m), 8'(r), 4'(st_in), 1'(h));
            chk("R8 compare flags", status_out, exp_st);
            chk("R8 compare leaves accumulator", {result_we, result_out}, 9'h05A);
            chk("R10 compare mask", status_we, 4'b1011);
         end
   endtask

   task automatic t_bit_test;
      int pats [5][2] = '{'{8'h0F, 8'hF0}, '{8'hFF, 8'h80}, '{8'h01, 8'h41},
                          '{8'h00, 8'hC0}, '{8'h3C, 8'h3C}};
      for (int p = 0; p < 5; p++)
         for (int h = 0; h < 2; h++) begin
            int a, m, st_in, exp_st;
            a = pats[p][0]; m = pats[p][1];
            st_in = h ? 4'hF : 4'h0;
            exp_st = (m & 8'hC0) >> 4 | (((a & m) == 0 ? 1 : 0) << 1) | (st_in & 1);
            drive(2'd3, 8'(a), 8'(m), 8'h00, 4'(st_in), 1'b0);
            chk("R9 bit-test flags", status_out, exp_st);
            chk("R9 bit-test leaves accumulator", {result_we, result_out}, a);
            chk("R10 bit-test mask", status_we, 4'b1110);
         end
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got 0x0 expected 0x1");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      #5 rst_n = 1'b1;
      t_power_on();
      t_bin_add_all();
      t_bin_sub_all();
      t_dec_add_all();
      t_dec_sub_all();
      t_compare();
      t_bit_test();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule